// File: doc/BRIEF.md
# Self-Checking Ripple-Borrow Subtractor

This block subtracts one N-bit unsigned operand and a borrow-in from another, one bit slice at a time. The borrow produced by each slice is the borrow-in of the next slice up. Each slice has a small concurrent guard of its own. The guard takes the XNOR of the slice's difference and borrow outputs. It compares that value with a second Boolean function that it predicts from the same three slice inputs. When the slice is healthy, these two values are always complements of each other. A single wrong output net breaks that relation and raises the slice's error bit.

A fault-injection port can force the difference output, the borrow output, or both outputs of any slice to a chosen level. The forced value is applied before the guard and before the next slice, so the guard sees exactly what the downstream logic sees. A clocked flag collects all slice errors into one bit for system monitoring. The scheme reports that a slice is faulty. It does not report which of the two outputs of that slice is wrong.

Top module: `selfcheck_sub`

## Requirements
- R1: With no force enable set, `diff_out` equals (`a_in` − `b_in` − `borrow_in`) modulo 2^WIDTH.
- R2: With no force enable set, `borrow_out` is 1 exactly when `a_in` < `b_in` + `borrow_in`, taken as unsigned values.
- R3: With no force enable set, every bit of `slice_err` is 0, for all operand values and every value of `borrow_in`.
- R4: When `fdiff_en[i]` is 1, bit i of `diff_out` equals `fault_level[i]`, and the other difference bits are those of the fault-free chain. Bit i of any vector belongs to slice i, and slice 0 is the least significant bit.
- R5: When `fbrw_en[i]` is 1, the borrow leaving slice i equals `fault_level[i]`. For slices below the top, that borrow is the borrow-in of slice i+1. For the top slice, it is `borrow_out`. The slices above slice i compute correctly from the forced borrow and raise no error.
- R6: `slice_err[i]` is 1 exactly when one of slice i's two outputs differs from its fault-free value for that slice's actual inputs, and the other output does not differ. A single stuck output that changes the result is therefore always flagged.
- R7: `err_any` is a register. One clock edge after `rst` is sampled low, it holds the OR of `slice_err` as sampled at that edge.
- R8: A synchronous, active-high `rst` clears `err_any` to 0 at the next clock edge. This holds even while a slice is reporting an error.
- R9: `fault_level` has no effect on any output when the slice's two force enables are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the error register |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Minuend |
| b_in | input | WIDTH | Subtrahend |
| borrow_in | input | 1 | Borrow into slice 0 |
| fdiff_en | input | WIDTH | Per slice: force the difference output |
| fbrw_en | input | WIDTH | Per slice: force the borrow output |
| fault_level | input | WIDTH | Per slice: level used for the forced output(s) |
| diff_out | output | WIDTH | Difference word, after any forcing |
| borrow_out | output | 1 | Borrow leaving the top slice, after any forcing |
| slice_err | output | WIDTH | Per-slice guard result, 1 means a fault was seen |
| err_any | output | 1 | Registered OR of all slice errors |

## Verification
The difference word, `borrow_out` and `slice_err` are combinational and settle in the same cycle as their inputs. The bench therefore drives inputs on the falling edge and compares these outputs a moment later, before the next rising edge. `err_any` is due one rising edge later. The bench keeps the expected OR from the comparison cycle and checks it just after that rising edge, and it checks the reset clear at the edge where `rst` is sampled high.

// File: rtl/selfcheck_sub_pkg.sv
package selfcheck_sub_pkg;

    typedef enum logic {
        STUCK_LO = 1'b0,
        STUCK_HI = 1'b1
    } stuck_lvl_e;

    typedef struct packed {
        logic diff;
        logic brw;
    } sub_res_t;

    typedef struct packed {
        logic       hit_diff;
        logic       hit_brw;
        stuck_lvl_e level;
    } flt_ctl_t;

    // Fault-free one-bit subtraction a - b - c.
    function automatic sub_res_t sub_bit(input logic a, input logic b, input logic c);
        sub_res_t r;
        r.diff = a ^ b ^ c;
        r.brw  = (~a & b) | (~a & c) | (b & c);
        return r;
    endfunction

    // Term predicted from the inputs alone; a healthy slice always has
    // XNOR(diff, brw) equal to its complement.
    function automatic logic predict_term(input logic a, input logic b, input logic c);
        return (a & ~b & ~c) | (~a & b & c);
    endfunction

    function automatic sub_res_t apply_fault(input sub_res_t raw, input flt_ctl_t f);
        sub_res_t r;
        r.diff = f.hit_diff ? logic'(f.level) : raw.diff;
        r.brw  = f.hit_brw  ? logic'(f.level) : raw.brw;
        return r;
    endfunction

endpackage

// File: rtl/selfcheck_sub_slice.sv
module selfcheck_sub_slice
    import selfcheck_sub_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  logic     c,
    input  flt_ctl_t flt,
    output sub_res_t res
);
    sub_res_t raw;

    always_comb begin
        raw = sub_bit(a, b, c);
        res = apply_fault(raw, flt);
    end
endmodule

// File: rtl/selfcheck_sub_guard.sv
module selfcheck_sub_guard
    import selfcheck_sub_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  logic     c,
    input  sub_res_t res,
    output logic     err
);
    logic same_out;
    logic pred;

    always_comb begin
        same_out = ~(res.diff ^ res.brw);
        pred     = predict_term(a, b, c);
        err      = ~(same_out ^ pred);
    end
endmodule

// File: rtl/selfcheck_sub.sv
module selfcheck_sub
    import selfcheck_sub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             borrow_in,
    input  logic [WIDTH-1:0] fdiff_en,
    input  logic [WIDTH-1:0] fbrw_en,
    input  logic [WIDTH-1:0] fault_level,
    output logic [WIDTH-1:0] diff_out,
    output logic             borrow_out,
    output logic [WIDTH-1:0] slice_err,
    output logic             err_any
);
    localparam int CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] brw_chain;
    sub_res_t         res [WIDTH];
    flt_ctl_t         ctl [WIDTH];

    assign brw_chain[0] = borrow_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        always_comb begin
            ctl[i].hit_diff = fdiff_en[i];
            ctl[i].hit_brw  = fbrw_en[i];
            ctl[i].level    = stuck_lvl_e'(fault_level[i]);
        end

        selfcheck_sub_slice u_slice (
            .a   (a_in[i]),
            .b   (b_in[i]),
            .c   (brw_chain[i]),
            .flt (ctl[i]),
            .res (res[i])
        );

        selfcheck_sub_guard u_guard (
            .a   (a_in[i]),
            .b   (b_in[i]),
            .c   (brw_chain[i]),
            .res (res[i]),
            .err (slice_err[i])
        );

        assign diff_out[i]    = res[i].diff;
        assign brw_chain[i+1] = res[i].brw;
    end

    assign borrow_out = brw_chain[WIDTH];

    always_ff @(posedge clk) begin
        if (rst) err_any <= 1'b0;
        else     err_any <= |slice_err;
    end
endmodule

// File: rtl/selfcheck_sub_sva.sv
module selfcheck_sub_sva #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             borrow_in,
    input logic [WIDTH-1:0] fdiff_en,
    input logic [WIDTH-1:0] fbrw_en,
    input logic [WIDTH-1:0] fault_level,
    input logic [WIDTH-1:0] diff_out,
    input logic             borrow_out,
    input logic [WIDTH-1:0] slice_err,
    input logic             err_any
);
    logic [WIDTH-1:0] ref_diff;
    logic             no_force;

    always_comb begin
        ref_diff = a_in - b_in - {{(WIDTH-1){1'b0}}, borrow_in};
        no_force = ~|(fdiff_en | fbrw_en);
    end

    assert_diff_value_R1: assert property (@(posedge clk) disable iff (rst)
        no_force |-> diff_out == ref_diff);

    assert_no_false_alarm_R3: assert property (@(posedge clk) disable iff (rst)
        no_force |-> slice_err == '0);

    for (genvar i = 0; i < WIDTH; i++) begin : g_force
        assert_forced_diff_R4: assert property (@(posedge clk) disable iff (rst)
            fdiff_en[i] |-> diff_out[i] == fault_level[i]);
    end

    assert_forced_top_borrow_R5: assert property (@(posedge clk) disable iff (rst)
        fbrw_en[WIDTH-1] |-> borrow_out == fault_level[WIDTH-1]);

    assert_err_register_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> err_any == $past(|slice_err));

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> !err_any);
endmodule

bind selfcheck_sub selfcheck_sub_sva #(.WIDTH(WIDTH)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .a_in        (a_in),
    .b_in        (b_in),
    .borrow_in   (borrow_in),
    .fdiff_en    (fdiff_en),
    .fbrw_en     (fbrw_en),
    .fault_level (fault_level),
    .diff_out    (diff_out),
    .borrow_out  (borrow_out),
    .slice_err   (slice_err),
    .err_any     (err_any)
);

// File: tb/selfcheck_sub_tb_top.sv
module selfcheck_sub_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         borrow_in = 1'b0;
    logic [W-1:0] fdiff_en = '0, fbrw_en = '0, fault_level = '0;
    logic [W-1:0] diff_out, slice_err;
    logic         borrow_out, err_any;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    selfcheck_sub #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .borrow_in(borrow_in),
        .fdiff_en(fdiff_en), .fbrw_en(fbrw_en), .fault_level(fault_level),
        .diff_out(diff_out), .borrow_out(borrow_out), .slice_err(slice_err),
        .err_any(err_any)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural bit-serial reference built on integer arithmetic.
    function automatic void model(
        input  logic [W-1:0] a, input logic [W-1:0] b, input logic bin,
        input  logic [W-1:0] fd, input logic [W-1:0] fb, input logic [W-1:0] lv,
        output logic [W-1:0] d, output logic bo, output logic [W-1:0] e);
        int c = int'(bin);
        for (int i = 0; i < W; i++) begin
            int   t  = int'(a[i]) - int'(b[i]) - c;
            logic td = (t == 1) || (t == -1);
            logic tb = (t < 0);
            logic od = fd[i] ? lv[i] : td;
            logic ob = fb[i] ? lv[i] : tb;
            d[i] = od;
            e[i] = (od != td) ^ (ob != tb);
            c    = int'(ob);
        end
        bo = logic'(c);
    endfunction

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic bin,
                       input logic [W-1:0] fd, input logic [W-1:0] fb, input logic [W-1:0] lv,
                       input string rd, input string rb, input string re);
        logic [W-1:0] xd, xe;
        logic         xb;
        logic         pend;
        @(negedge clk);
        a_in = a; b_in = b; borrow_in = bin;
        fdiff_en = fd; fbrw_en = fb; fault_level = lv;
        #1;
        model(a, b, bin, fd, fb, lv, xd, xb, xe);
        chk(rd, "diff_out", diff_out, xd);
        chk(rb, "borrow_out", {{(W-1){1'b0}}, borrow_out}, {{(W-1){1'b0}}, xb});
        chk(re, "slice_err", slice_err, xe);
        pend = |xe;
        @(posedge clk);
        #1;
        chk("R7", "err_any", {{(W-1){1'b0}}, err_any}, {{(W-1){1'b0}}, pend});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "err_any after reset", {{(W-1){1'b0}}, err_any}, '0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R2 R3: corners, then a random sweep with no forcing
        run(8'h00, 8'h00, 1'b0, '0, '0, '0, "R1", "R2", "R3");
        run(8'h00, 8'h00, 1'b1, '0, '0, '0, "R1", "R2", "R3");
        run(8'h00, 8'hFF, 1'b1, '0, '0, '0, "R1", "R2", "R3");
        run(8'hFF, 8'h00, 1'b0, '0, '0, '0, "R1", "R2", "R3");
        run(8'hFF, 8'hFF, 1'b1, '0, '0, '0, "R1", "R2", "R3");
        run(8'h80, 8'h7F, 1'b1, '0, '0, '0, "R1", "R2", "R3");
        for (int k = 0; k < 2000; k++)
            run(W'($urandom), W'($urandom), 1'($urandom), '0, '0, '0, "R1", "R2", "R3");

        // R9: fault_level toggles with no enable
        for (int k = 0; k < 200; k++)
            run(W'($urandom), W'($urandom), 1'($urandom), '0, '0, W'($urandom),
                "R9", "R9", "R9");

        // R4 R6: each slice difference stuck low and high
        for (int i = 0; i < W; i++)
            for (int l = 0; l < 2; l++)
                for (int k = 0; k < 24; k++)
                    run(W'($urandom), W'($urandom), 1'($urandom), W'(1) << i, '0,
                        l[0] ? (W'(1) << i) : '0, "R4", "R4", "R6");

        // R5 R6: each slice borrow stuck low and high
        for (int i = 0; i < W; i++)
            for (int l = 0; l < 2; l++)
                for (int k = 0; k < 24; k++)
                    run(W'($urandom), W'($urandom), 1'($urandom), '0, W'(1) << i,
                        l[0] ? (W'(1) << i) : '0, "R5", "R5", "R6");

        // R6: both outputs of one slice forced together
        for (int k = 0; k < 64; k++) begin
            logic [W-1:0] m = W'(1) << ($urandom % W);
            run(W'($urandom), W'($urandom), 1'($urandom), m, m, W'($urandom),
                "R6", "R6", "R6");
        end

        // R8: reset clears the flag while a fault is still reported
        run(8'h00, 8'h00, 1'b0, 8'h01, '0, 8'h01, "R4", "R2", "R6");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R8", "err_any under reset", {{(W-1){1'b0}}, err_any}, '0);
        @(negedge clk);
        rst = 1'b0;
        fdiff_en = '0;
        @(posedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule